// File: doc/BRIEF.md
# Handshaked Byte Link Transfer Engine

This block is the peripheral end of a byte-wide packet link to a host processor. The host paces every byte by writing a port register that carries three active-low handshake lines: a transfer-in-progress line, an acknowledge line, and a request line that the block alone drives. It does not use a serial clock. One data byte sits in a shift register. A direction bit in a control register picks the direction. With the bit set, the host pushes bytes into a 16-entry outbound buffer. With it clear, the block hands out the bytes of a queued inbound packet of up to 128 bytes, one per handshake edge.

A write to the port register, a write to the control register, or the start of a new inbound packet each trigger one evaluation step. That step compares the handshake lines against their values from the previous step. It can then capture or deliver a byte, update the request line, detect the end of a packet and raise the shift-register flag. When an outbound packet ends, a one-clock strobe reports its byte count, and the captured bytes can be read through a read port. Inbound packets are written into their buffer through a write port and then launched with a start pulse and a length.

Top module: `byte_link_xfer`

## Requirements
- R1: After reset, `portb_q` is 0x38 (bit 5 in-progress, bit 4 acknowledge and bit 3 request all high and inactive), `sr_q` is 0, and `sr_flag` and `pkt_done` are 0.
- R2: With `ctrl_q` bit 4 set and port bit 5 low, a port write that changes bit 4 or bit 5 relative to the previously evaluated value stores `sr_q` into the outbound buffer at the next index and sets `sr_flag`.
- R3: The outbound buffer holds at most OUT_DEPTH (16) bytes. An edge that arrives when the buffer is full stores nothing and does not set `sr_flag`.
- R4: A port write that leaves bits 4 and 5 unchanged during an active transfer captures and delivers nothing and does not set `sr_flag`.
- R5: With `ctrl_q` bit 4 clear, port bit 5 low and inbound bytes unread, each change of bit 4 or bit 5 loads the next inbound byte into `sr_q` and sets `sr_flag`.
- R6: When the last inbound byte is delivered, port bit 3 goes high. Later edges leave `sr_q` unchanged and do not set `sr_flag`.
- R7: A port write that raises bit 5 after it was low ends the transfer. `sr_flag` is set in every case. If at least one byte was captured, `pkt_done` pulses for exactly one cycle with `pkt_len` equal to the captured count, and the capture index returns to zero.
- R8: When bit 5 stays high and bit 4 toggles, port bit 3 takes the new bit-4 level and `sr_flag` is set.
- R9: When the link is idle and inbound bytes remain unread, and the R8 case does not apply, port bit 3 is driven low.
- R10: An `in_start` pulse sets the inbound length to `in_len`, capped at IN_DEPTH. It also resets the read index, sets `sr_flag` and runs an evaluation step.
- R11: `sr_flag_clr` clears `sr_flag`. A set in the same cycle takes priority over the clear.
- R12: The value that the host writes to port bit 3 is ignored. The block alone owns that bit.
- R13: `out_rd_data` returns the byte captured at index `out_rd_addr`, in capture order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| portb_we | input | 1 | Host write strobe for the handshake port |
| portb_wdata | input | 8 | Port write data (bit 5 in-progress, bit 4 acknowledge) |
| portb_q | output | 8 | Current port value, bit 3 the request line |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data, bit 4 direction |
| ctrl_q | output | 8 | Control register value |
| sr_we | input | 1 | Host write of the shift register |
| sr_wdata | input | 8 | Shift register write data |
| sr_q | output | 8 | Shift register value |
| sr_flag | output | 1 | Shift-register event flag |
| sr_flag_clr | input | 1 | Clears the flag |
| in_wr_en | input | 1 | Inbound buffer write enable |
| in_wr_addr | input | 7 | Inbound buffer write address |
| in_wr_data | input | 8 | Inbound buffer write data |
| in_start | input | 1 | Launches a queued inbound packet |
| in_len | input | 8 | Inbound packet length |
| pkt_done | output | 1 | One-cycle outbound packet complete strobe |
| pkt_len | output | 5 | Byte count of the completed packet |
| out_rd_addr | input | 4 | Outbound buffer read index |
| out_rd_data | output | 8 | Outbound buffer byte at that index |

## Verification
Every registered result appears on the clock edge that samples the triggering write or start pulse: the port, shift register, flag, strobe and count. The bench drives each stimulus for one cycle from the falling edge and checks at the next falling edge. `pkt_done` is checked high there and low one cycle later. The outbound read port is combinational, so it is sampled shortly after the address changes. The bench sweeps outbound packet lengths 1 to 18, which crosses the 16-byte limit, and inbound lengths up to the full 128 bytes. Expected bytes come from arithmetic on the length and the index.

// File: rtl/byte_link_pkg.sv
package byte_link_pkg;

    localparam int REQ_BIT = 3;
    localparam int ACK_BIT = 4;
    localparam int TIP_BIT = 5;
    localparam int DIR_BIT = 4;
    localparam logic [7:0] PORT_RESET = 8'h38;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_CAPTURE,
        EV_DELIVER,
        EV_SYNC,
        EV_END
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e kind;
        logic     set_flag;
        logic     req_set;
        logic     req_val;
        logic     pkt_fire;
    } ev_t;

    function automatic logic hs_moved(input logic [7:0] cur, input logic [7:0] prev);
        return (cur[TIP_BIT] != prev[TIP_BIT]) || (cur[ACK_BIT] != prev[ACK_BIT]);
    endfunction

endpackage

// File: rtl/link_decide.sv
module link_decide
    import byte_link_pkg::*;
(
    input  logic       eval_en,
    input  logic [7:0] cur_b,
    input  logic [7:0] last_b,
    input  logic       dir_out,
    input  logic       out_room,
    input  logic       out_any,
    input  logic       in_pending,
    input  logic       in_last,
    output ev_t        ev
);
    always_comb begin
        ev = '{kind: EV_NONE, set_flag: 1'b0, req_set: 1'b0, req_val: 1'b0, pkt_fire: 1'b0};
        if (eval_en) begin
            if (!cur_b[TIP_BIT]) begin
                if (dir_out) begin
                    if (hs_moved(cur_b, last_b) && out_room) begin
                        ev.kind     = EV_CAPTURE;
                        ev.set_flag = 1'b1;
                    end
                end else if (in_pending && hs_moved(cur_b, last_b)) begin
                    ev.kind     = EV_DELIVER;
                    ev.set_flag = 1'b1;
                    if (in_last) begin
                        ev.req_set = 1'b1;
                        ev.req_val = 1'b1;
                    end
                end
            end else if (last_b[TIP_BIT] && (cur_b[ACK_BIT] != last_b[ACK_BIT])) begin
                ev.kind     = EV_SYNC;
                ev.set_flag = 1'b1;
                ev.req_set  = 1'b1;
                ev.req_val  = cur_b[ACK_BIT];
            end else begin
                if (!last_b[TIP_BIT]) begin
                    ev.kind     = EV_END;
                    ev.set_flag = 1'b1;
                    ev.pkt_fire = out_any;
                end
                if (in_pending) begin
                    ev.req_set = 1'b1;
                    ev.req_val = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/out_capture.sv
module out_capture #(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          clear,
    input  logic [7:0]    din,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data,
    output logic [CW-1:0] count,
    output logic          room,
    output logic          any
);
    logic [7:0] mem [DEPTH];

    assign room    = count < CW'(DEPTH);
    assign any     = count != '0;
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (capture) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (capture && room) begin
            mem[count[AW-1:0]] <= din;
        end
    end

    assert_count_cap_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));
    assert_cap_room_R3: assert property (@(posedge clk) disable iff (rst)
        capture |-> count < CW'(DEPTH));
endmodule

// File: rtl/in_queue.sv
module in_queue #(
    parameter int DEPTH = 128,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          start,
    input  logic [CW-1:0] len,
    input  logic          advance,
    output logic          pending,
    output logic          last,
    output logic [7:0]    head
);
    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] idx_q, size_q;
    logic [CW-1:0] len_cap, eff_idx, eff_size;
    logic [CW:0]   next_idx;

    assign len_cap  = (len > CW'(DEPTH)) ? CW'(DEPTH) : len;
    assign eff_idx  = start ? '0 : idx_q;
    assign eff_size = start ? len_cap : size_q;
    assign next_idx = {1'b0, eff_idx} + 1'b1;
    assign pending  = eff_idx < eff_size;
    assign last     = next_idx >= {1'b0, eff_size};
    assign head     = mem[eff_idx[AW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            size_q <= '0;
        end else begin
            if (start) size_q <= len_cap;
            if (advance) idx_q <= next_idx[CW-1:0];
            else if (start) idx_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assert_adv_pending_R6: assert property (@(posedge clk) disable iff (rst)
        advance |-> pending);
endmodule

// File: rtl/byte_link_xfer.sv
module byte_link_xfer
    import byte_link_pkg::*;
#(
    parameter int OUT_DEPTH = 16,
    parameter int IN_DEPTH  = 128,
    localparam int OCW = $clog2(OUT_DEPTH + 1),
    localparam int OAW = $clog2(OUT_DEPTH),
    localparam int ICW = $clog2(IN_DEPTH + 1),
    localparam int IAW = $clog2(IN_DEPTH)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           portb_we,
    input  logic [7:0]     portb_wdata,
    output logic [7:0]     portb_q,
    input  logic           ctrl_we,
    input  logic [7:0]     ctrl_wdata,
    output logic [7:0]     ctrl_q,
    input  logic           sr_we,
    input  logic [7:0]     sr_wdata,
    output logic [7:0]     sr_q,
    output logic           sr_flag,
    input  logic           sr_flag_clr,
    input  logic           in_wr_en,
    input  logic [IAW-1:0] in_wr_addr,
    input  logic [7:0]     in_wr_data,
    input  logic           in_start,
    input  logic [ICW-1:0] in_len,
    output logic           pkt_done,
    output logic [OCW-1:0] pkt_len,
    input  logic [OAW-1:0] out_rd_addr,
    output logic [7:0]     out_rd_data
);
    logic [7:0]     last_q, b_cur, b_next, acr_cur;
    logic           eval_en;
    logic           in_pending, in_last;
    logic [7:0]     in_head;
    logic [OCW-1:0] out_count;
    logic           out_room, out_any;
    ev_t            ev;

    always_comb begin
        b_cur = portb_q;
        if (portb_we) begin
            b_cur          = portb_wdata;
            b_cur[REQ_BIT] = portb_q[REQ_BIT];
        end
    end

    assign acr_cur = ctrl_we ? ctrl_wdata : ctrl_q;
    assign eval_en = portb_we | ctrl_we | in_start;

    in_queue #(.DEPTH(IN_DEPTH)) inq_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_wr_en),
        .wr_addr (in_wr_addr),
        .wr_data (in_wr_data),
        .start   (in_start),
        .len     (in_len),
        .advance (ev.kind == EV_DELIVER),
        .pending (in_pending),
        .last    (in_last),
        .head    (in_head)
    );

    out_capture #(.DEPTH(OUT_DEPTH)) outc_i (
        .clk     (clk),
        .rst     (rst),
        .capture (ev.kind == EV_CAPTURE),
        .clear   (ev.kind == EV_END),
        .din     (sr_q),
        .rd_addr (out_rd_addr),
        .rd_data (out_rd_data),
        .count   (out_count),
        .room    (out_room),
        .any     (out_any)
    );

    link_decide dec_i (
        .eval_en    (eval_en),
        .cur_b      (b_cur),
        .last_b     (last_q),
        .dir_out    (acr_cur[DIR_BIT]),
        .out_room   (out_room),
        .out_any    (out_any),
        .in_pending (in_pending),
        .in_last    (in_last),
        .ev         (ev)
    );

    always_comb begin
        b_next = b_cur;
        if (ev.req_set) b_next[REQ_BIT] = ev.req_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            portb_q  <= PORT_RESET;
            last_q   <= PORT_RESET;
            ctrl_q   <= '0;
            sr_q     <= '0;
            sr_flag  <= 1'b0;
            pkt_done <= 1'b0;
            pkt_len  <= '0;
        end else begin
            ctrl_q <= acr_cur;
            if (eval_en) begin
                portb_q <= b_next;
                last_q  <= b_next;
            end
            if (ev.kind == EV_DELIVER) sr_q <= in_head;
            else if (sr_we)            sr_q <= sr_wdata;
            if (ev.set_flag || in_start) sr_flag <= 1'b1;
            else if (sr_flag_clr)        sr_flag <= 1'b0;
            pkt_done <= ev.pkt_fire;
            if (ev.pkt_fire) pkt_len <= out_count;
        end
    end

    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_done |=> !pkt_done);
    assert_pulse_len_R7: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> pkt_len != '0);
    assert_sync_follow_R8: assert property (@(posedge clk) disable iff (rst)
        (eval_en && ev.kind == EV_SYNC) |=> portb_q[REQ_BIT] == $past(b_cur[ACK_BIT]));
    assert_flag_set_R2: assert property (@(posedge clk) disable iff (rst)
        (eval_en && ev.set_flag) |=> sr_flag);
endmodule

// File: tb/byte_link_xfer_tb_top.sv
`timescale 1ns/1ps
module byte_link_xfer_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       portb_we = 0, ctrl_we = 0, sr_we = 0, sr_flag_clr = 0;
    logic [7:0] portb_wdata = 0, ctrl_wdata = 0, sr_wdata = 0;
    logic [7:0] portb_q, ctrl_q, sr_q, in_wr_data = 0, out_rd_data;
    logic       sr_flag, in_wr_en = 0, in_start = 0, pkt_done;
    logic [6:0] in_wr_addr = 0;
    logic [7:0] in_len = 0;
    logic [4:0] pkt_len;
    logic [3:0] out_rd_addr = 0;

    int  vectors = 0, misses = 0;
    bit  done = 0;
    bit  ack = 1;

    always #2.5 clk = ~clk;

    byte_link_xfer dut_i (
        .clk(clk), .rst(rst),
        .portb_we(portb_we), .portb_wdata(portb_wdata), .portb_q(portb_q),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .sr_q(sr_q),
        .sr_flag(sr_flag), .sr_flag_clr(sr_flag_clr),
        .in_wr_en(in_wr_en), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
        .in_start(in_start), .in_len(in_len),
        .pkt_done(pkt_done), .pkt_len(pkt_len),
        .out_rd_addr(out_rd_addr), .out_rd_data(out_rd_data)
    );

    function automatic logic [7:0] obyte(int n, int i);
        return 8'((n * 37 + i * 11 + 5) & 255);
    endfunction
    function automatic logic [7:0] ibyte(int m, int i);
        return 8'((m * 13 + i * 29 + 71) & 255);
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_raw(logic [7:0] d);
        @(negedge clk); portb_we = 1; portb_wdata = d;
        @(negedge clk); portb_we = 0;
    endtask
    task automatic wr_b(bit tip, bit a);
        wr_raw({2'b00, tip, a, 4'b0000});
    endtask
    task automatic wr_ctrl(logic [7:0] d);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = d;
        @(negedge clk); ctrl_we = 0;
    endtask
    task automatic wr_sr(logic [7:0] d);
        @(negedge clk); sr_we = 1; sr_wdata = d;
        @(negedge clk); sr_we = 0;
    endtask
    task automatic clr_flag();
        @(negedge clk); sr_flag_clr = 1;
        @(negedge clk); sr_flag_clr = 0;
    endtask
    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 199000);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle();
        // R1 reset state
        check("R1 portb", portb_q, 8'h38);
        check("R1 sr", sr_q, 0);
        check("R1 flag", sr_flag, 0);
        check("R1 done", pkt_done, 0);

        // Host-to-device sweep, lengths 1..18 (R2 R3 R4 R7 R13)
        for (int n = 1; n <= 18; n++) begin
            wr_ctrl(8'h10);
            clr_flag();
            for (int i = 0; i < n; i++) begin
                wr_sr(obyte(n, i));
                if (i != 0) ack = ~ack;
                wr_b(0, ack);
                if (i < 16) check("R2 capture flag", sr_flag, 1);
                else        check("R3 full no flag", sr_flag, 0);
                clr_flag();
                if (n == 5 && i == 1) begin
                    wr_b(0, ack);
                    check("R4 no edge no flag", sr_flag, 0);
                end
            end
            wr_b(1, ack);
            check("R7 done pulse", pkt_done, 1);
            check("R7 length", pkt_len, (n > 16) ? 16 : n);
            check("R7 flag at end", sr_flag, 1);
            idle();
            check("R7 pulse one cycle", pkt_done, 0);
            for (int j = 0; j < ((n > 16) ? 16 : n); j++) begin
                out_rd_addr = 4'(j);
                #1;
                check("R13 readback", out_rd_data, obyte(n, j));
            end
        end

        // Device-to-host (R5 R6 R7 R9 R10)
        wr_ctrl(8'h00);
        for (int k = 0; k < 6; k++) begin
            int m;
            m = (k == 5) ? 128 : ((k == 4) ? 7 : k + 1);
            for (int i = 0; i < m; i++) begin
                @(negedge clk); in_wr_en = 1; in_wr_addr = 7'(i); in_wr_data = ibyte(m, i);
            end
            @(negedge clk); in_wr_en = 0;
            clr_flag();
            @(negedge clk); in_start = 1; in_len = 8'(m);
            @(negedge clk); in_start = 0;
            check("R10 start flag", sr_flag, 1);
            check("R9 request low", portb_q[3], 0);
            clr_flag();
            for (int i = 0; i < m; i++) begin
                if (i == 0) wr_b(0, ack);
                else begin ack = ~ack; wr_b(0, ack); end
                check("R5 deliver byte", sr_q, ibyte(m, i));
                check("R5 deliver flag", sr_flag, 1);
                check("R6 request level", portb_q[3], (i == m - 1) ? 1 : 0);
                clr_flag();
            end
            ack = ~ack;
            wr_b(0, ack);
            check("R6 no byte after last", sr_q, ibyte(m, m - 1));
            check("R6 no flag after last", sr_flag, 0);
            wr_b(1, ack);
            check("R7 no pulse when empty", pkt_done, 0);
            check("R7 flag when empty", sr_flag, 1);
            check("R6 request stays high", portb_q[3], 1);
        end

        // Idle sync (R8) and flag priority (R11) and owned bit (R12)
        clr_flag();
        ack = ~ack;
        wr_b(1, ack);
        check("R8 follow", portb_q[3], ack);
        check("R8 flag", sr_flag, 1);
        ack = ~ack;
        @(negedge clk); portb_we = 1; portb_wdata = {2'b00, 1'b1, ack, 4'b0000}; sr_flag_clr = 1;
        @(negedge clk); portb_we = 0; sr_flag_clr = 0;
        check("R8 follow again", portb_q[3], ack);
        check("R11 set beats clear", sr_flag, 1);
        clr_flag();
        check("R11 clear", sr_flag, 0);
        if (!ack) begin
            ack = 1;
            wr_b(1, ack);
        end
        wr_raw({2'b00, 1'b1, ack, 4'b0000});
        check("R12 host bit ignored", portb_q[3], 1);
        wr_raw({2'b00, 1'b1, ack, 4'b1000});
        check("R12 host bit ignored set", portb_q[3], 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule